// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache

This block is a direct-mapped data cache placed between a processor load/store port and a main-memory port. The processor presents a byte address, a read/write flag and a write byte, and holds them until the cache raises its ready signal. A lookup that finds the addressed line present completes in the cycle it is presented. Otherwise the cache moves a whole 8-byte line over the memory port. If the line being replaced holds modified data, that line goes back to memory first. Writes change only the cached copy and mark the line as modified.

Two maintenance commands serve software that hands memory to a DMA engine or switches context. Flush copies every modified line back to memory and leaves the contents valid. Invalidate-all copies modified lines back and then clears every line. Both walk the lines from index 0 upward and end with a one-cycle completion pulse. The memory port uses a request/acknowledge handshake: the cache holds a request with a stable address until memory returns a one-cycle acknowledge.

Top module: `wb_dm_cache`

## Requirements
- R1: An address splits into bits [2:0] as the byte within the line, the next IDX_W bits as the line index, and all higher bits as the tag. A lookup hits only when the indexed line is valid and its stored tag equals the address tag. Byte k of a line travels on bits [8k+7:8k] of the memory line buses.
- R2: Reset clears every valid and modified flag, so the first access to any line after reset is a miss.
- R3: A read hit raises cpu_ready in the same cycle the request is presented, returns the addressed byte on cpu_rdata, and causes no memory traffic. cpu_ready is never high while a memory request is active.
- R4: A read miss to a line that is not modified issues exactly one memory read for the line address {tag, index}. It stores the returned line with its tag, and the request then completes as a hit.
- R5: A write hit changes only the cached byte, issues no memory transfer, and marks the line modified.
- R6: A write miss first fetches the line, then merges the written byte into it. Later reads return the merged byte, and the other seven bytes keep their memory values.
- R7: Replacing a modified line first writes the old line to memory at {old tag, index}, then fetches the new line: one write followed by one read.
- R8: Replacing a valid but unmodified line issues no memory write.
- R9: A flush writes back every valid modified line exactly once, in ascending index order. Afterwards, memory holds the current data and all lines remain valid and unmodified, so an immediate second flush writes nothing.
- R10: An invalidate-all writes back every modified line, in ascending index order, and then leaves every line invalid, so later accesses miss.
- R11: A maintenance command is accepted in the idle state and ends with maint_done high for exactly one cycle.
- R12: Once raised, mem_req stays high, with mem_addr and mem_we unchanged, until the cycle in which mem_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write byte, 0 = read byte |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid while cpu_ready |
| cpu_ready | output | 1 | Access completes at this clock edge |
| cmd_flush | input | 1 | Start a flush (idle only) |
| cmd_inval | input | 1 | Start an invalidate-all (idle only) |
| maint_done | output | 1 | One-cycle end-of-maintenance pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | ADDR_W-3 | Line address |
| mem_wline | output | 64 | Line being written back |
| mem_rline | input | 64 | Fetched line, valid with mem_ack |
| mem_ack | input | 1 | One-cycle transfer acknowledge |

## Verification
With a memory latency of L cycles, a hit shows cpu_ready in the same cycle as the request. A miss to an unmodified line shows it L+2 cycles later, and a miss that evicts a modified line shows it 2L+3 cycles later. The bench drives each request at a falling edge and samples ready and read data 1 ns after each later falling edge. It counts the cycles of low ready and compares that count and the number of memory reads and writes with a shadow model of tags, valid flags and modified flags. After each maintenance command, the bench compares the whole backing memory with the architectural byte image and the order of the write-backs with ascending index. It also checks that the completion pulse has dropped one cycle after it appears.

// File: rtl/cache_pkg.sv
// Shared constants and types for the write-back direct-mapped cache.
// Assumes a fixed line of 8 bytes; byte k sits at bits [8k+7:8k].
package cache_pkg;
    localparam int LINE_BYTES = 8;
    localparam int OFF_W      = 3;
    localparam int LINE_W     = LINE_BYTES * 8;

    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic [2:0] {
        ST_IDLE,   // lookup / accept commands
        ST_EVICT,  // write back modified victim before a fill
        ST_FILL,   // fetch the missing line
        ST_SCAN,   // maintenance: inspect line at pointer
        ST_DRAIN   // maintenance: write back line at pointer
    } cache_state_t;
endpackage

// File: rtl/cache_store.sv
// Line storage: per-line valid and modified flags, tag and data.
// All operations address the single line selected by idx. Assumes
// the controller never asserts wr_en together with fill_en or clean_en.
module cache_store
    import cache_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  line_t             fill_line,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [7:0]        wr_byte,
    input  logic              clean_en,
    input  logic              drop_en,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output line_t             rd_line
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_vec;
    logic [LINES-1:0] dirty_vec;
    logic [TAG_W-1:0] tag_arr  [LINES];
    line_t            data_arr [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic             sel;
        logic             v_q;
        logic             d_q;
        logic [TAG_W-1:0] t_q;
        line_t            l_q;

        assign sel = (idx == IDX_W'(g));

        // Flags: set by fill/write, cleared by reset, write-back or drop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
            end else begin
                if (sel && fill_en)       v_q <= 1'b1;
                else if (sel && drop_en)  v_q <= 1'b0;
                if (sel && (fill_en || clean_en)) d_q <= 1'b0;
                else if (sel && wr_en)            d_q <= 1'b1;
            end
        end

        // Tag and data: whole-line load on fill, single-byte merge on write.
        always_ff @(posedge clk) begin
            if (sel && fill_en) begin
                t_q <= fill_tag;
                l_q <= fill_line;
            end else if (sel && wr_en) begin
                l_q[{wr_off, 3'b000} +: 8] <= wr_byte;
            end
        end

        assign valid_vec[g] = v_q;
        assign dirty_vec[g] = d_q;
        assign tag_arr[g]   = t_q;
        assign data_arr[g]  = l_q;
    end

    assign rd_valid = valid_vec[idx];
    assign rd_dirty = dirty_vec[idx];
    assign rd_tag   = tag_arr[idx];
    assign rd_line  = data_arr[idx];

    p_fill_sets_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid_vec[$past(idx)] && !dirty_vec[$past(idx)]);
    p_write_marks_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> dirty_vec[$past(idx)]);
    p_drop_clears_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drop_en |=> !valid_vec[$past(idx)]);
endmodule

// File: rtl/cache_lookup.sv
// Address decomposition, tag compare and byte selection.
// Purely combinational; assumes ADDR_W > IDX_W + 3.
module cache_lookup
    import cache_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              line_valid,
    input  logic [TAG_W-1:0]  line_tag,
    input  line_t             line_data,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag,
    output logic [OFF_W-1:0]  off,
    output logic              hit,
    output logic [7:0]        rbyte
);
    // Field split and hit decision.
    always_comb begin
        off   = addr[OFF_W-1:0];
        idx   = addr[OFF_W +: IDX_W];
        tag   = addr[ADDR_W-1 -: TAG_W];
        hit   = line_valid && (line_tag == tag);
        rbyte = line_data[{off, 3'b000} +: 8];
    end
endmodule

// File: rtl/cache_ctrl.sv
// Controller: miss handling (evict then fill) and the maintenance
// walk for flush and invalidate-all. Assumes the CPU holds its request
// stable until cpu_ready and that memory acks each request once.
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic             hit,
    input  logic             cmd_flush,
    input  logic             cmd_inval,
    input  logic             rd_valid,
    input  logic             rd_dirty,
    input  logic             mem_ack,
    output logic             use_ptr,
    output logic [IDX_W-1:0] ptr,
    output logic             cpu_ready,
    output logic             fill_en,
    output logic             wr_en,
    output logic             clean_en,
    output logic             drop_en,
    output logic             mem_req,
    output logic             mem_we,
    output logic             maint_done
);
    cache_state_t state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic inval_q, inval_d;
    logic done_d;
    logic last;

    assign last = (ptr_q == {IDX_W{1'b1}});

    // Next state and per-cycle strobes.
    always_comb begin
        state_d   = state_q;
        ptr_d     = ptr_q;
        inval_d   = inval_q;
        done_d    = 1'b0;
        cpu_ready = 1'b0;
        fill_en   = 1'b0;
        wr_en     = 1'b0;
        clean_en  = 1'b0;
        drop_en   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_flush || cmd_inval) begin
                    state_d = ST_SCAN;
                    ptr_d   = '0;
                    inval_d = cmd_inval;
                end else if (cpu_req && hit) begin
                    cpu_ready = 1'b1;
                    wr_en     = cpu_we;
                end else if (cpu_req) begin
                    state_d = (rd_valid && rd_dirty) ? ST_EVICT : ST_FILL;
                end
            end
            ST_EVICT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    clean_en = 1'b1;
                    state_d  = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fill_en = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_SCAN: begin
                if (rd_valid && rd_dirty) begin
                    state_d = ST_DRAIN;
                end else begin
                    drop_en = inval_q;
                    if (last) begin
                        done_d  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        ptr_d = ptr_q + 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    clean_en = 1'b1;
                    drop_en  = inval_q;
                    if (last) begin
                        done_d  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        ptr_d   = ptr_q + 1'b1;
                        state_d = ST_SCAN;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, walk pointer, mode and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ptr_q      <= '0;
            inval_q    <= 1'b0;
            maint_done <= 1'b0;
        end else begin
            state_q    <= state_d;
            ptr_q      <= ptr_d;
            inval_q    <= inval_d;
            maint_done <= done_d;
        end
    end

    assign ptr     = ptr_q;
    assign use_ptr = (state_q == ST_SCAN) || (state_q == ST_DRAIN);

    p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we));
    p_done_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        maint_done |=> !maint_done);
    p_wb_only_modified_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> rd_valid && rd_dirty);
    p_walk_ascends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        use_ptr && $past(use_ptr) && (ptr != $past(ptr)) |-> ptr == $past(ptr) + 1'b1);
endmodule

// File: rtl/wb_dm_cache.sv
// Top: write-back direct-mapped cache with flush and invalidate-all.
// Assumes cpu_req/cpu_addr/cpu_we/cpu_wdata stay stable until cpu_ready,
// and commands are raised only while no access is outstanding.
module wb_dm_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int LA_W  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_ready,
    input  logic              cmd_flush,
    input  logic              cmd_inval,
    output logic              maint_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [LA_W-1:0]   mem_addr,
    output logic [LINE_W-1:0] mem_wline,
    input  logic [LINE_W-1:0] mem_rline,
    input  logic              mem_ack
);
    logic [IDX_W-1:0] cpu_idx, ptr, idx_sel;
    logic [TAG_W-1:0] cpu_tag, rd_tag;
    logic [OFF_W-1:0] cpu_off;
    logic             hit, use_ptr, rd_valid, rd_dirty;
    logic             fill_en, wr_en, clean_en, drop_en;
    line_t            rd_line;

    assign idx_sel = use_ptr ? ptr : cpu_idx;

    cache_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lookup (
        .addr       (cpu_addr),
        .line_valid (rd_valid),
        .line_tag   (rd_tag),
        .line_data  (rd_line),
        .idx        (cpu_idx),
        .tag        (cpu_tag),
        .off        (cpu_off),
        .hit        (hit),
        .rbyte      (cpu_rdata)
    );

    cache_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx_sel),
        .fill_en   (fill_en),
        .fill_tag  (cpu_tag),
        .fill_line (mem_rline),
        .wr_en     (wr_en),
        .wr_off    (cpu_off),
        .wr_byte   (cpu_wdata),
        .clean_en  (clean_en),
        .drop_en   (drop_en),
        .rd_valid  (rd_valid),
        .rd_dirty  (rd_dirty),
        .rd_tag    (rd_tag),
        .rd_line   (rd_line)
    );

    cache_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .hit        (hit),
        .cmd_flush  (cmd_flush),
        .cmd_inval  (cmd_inval),
        .rd_valid   (rd_valid),
        .rd_dirty   (rd_dirty),
        .mem_ack    (mem_ack),
        .use_ptr    (use_ptr),
        .ptr        (ptr),
        .cpu_ready  (cpu_ready),
        .fill_en    (fill_en),
        .wr_en      (wr_en),
        .clean_en   (clean_en),
        .drop_en    (drop_en),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .maint_done (maint_done)
    );

    // Write-backs use the stored tag; fetches use the requested tag.
    assign mem_addr  = mem_we ? {rd_tag, idx_sel} : {cpu_tag, cpu_idx};
    assign mem_wline = rd_line;

    p_ready_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);
    p_addr_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> $stable(mem_addr));
    p_write_is_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && cpu_we |=> !mem_req);
endmodule

// File: tb/test_wb_dm_cache.sv
module test_wb_dm_cache;
    localparam int AW    = 10;
    localparam int IW    = 2;
    localparam int LAT   = 3;
    localparam int LINES = 1 << IW;
    localparam int TW    = AW - IW - 3;
    localparam int NB    = 1 << AW;
    localparam int NL    = NB / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0, cpu_rdata;
    logic cpu_ready, cmd_flush = 1'b0, cmd_inval = 1'b0, maint_done;
    logic mem_req, mem_we, mem_ack = 1'b0;
    logic [AW-4:0] mem_addr;
    logic [63:0] mem_wline, mem_rline = '0;

    int checks = 0, errors = 0;
    int nrd = 0, nwr = 0, cnt = 0, proto_err = 0;
    int wb_n = 0;
    int wb_idx [64];
    logic [7:0] bmem [NB];
    logic [7:0] rmem [NB];
    int  mtag [LINES];
    bit  mv [LINES];
    bit  md [LINES];

    always #5 clk = ~clk;

    wb_dm_cache #(.ADDR_W(AW), .IDX_W(IW)) i_wb_dm_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .cmd_flush(cmd_flush), .cmd_inval(cmd_inval),
        .maint_done(maint_done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wline(mem_wline), .mem_rline(mem_rline),
        .mem_ack(mem_ack)
    );

    function automatic logic [7:0] init_byte(int a);
        return 8'((a * 13) + (a >> 8) + 5);
    endfunction

    // Fixed-latency line memory; byte k of a line on bits [8k+7:8k].
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            cnt = 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (cnt == LAT - 1) begin
                    cnt = 0;
                    mem_ack <= 1'b1;
                    if (mem_we) begin
                        for (int k = 0; k < 8; k++)
                            bmem[{mem_addr, 3'(k)}] = mem_wline[8*k +: 8];
                        nwr++;
                        if (wb_n < 64) begin
                            wb_idx[wb_n] = int'(mem_addr[IW-1:0]);
                            wb_n++;
                        end
                    end else begin
                        for (int k = 0; k < 8; k++)
                            mem_rline[8*k +: 8] <= bmem[{mem_addr, 3'(k)}];
                        nrd++;
                    end
                end else begin
                    cnt++;
                end
            end
        end
    end

    // R12 monitor: request, address and direction held until acknowledge.
    logic pend = 1'b0, pwe = 1'b0;
    logic [AW-4:0] paddr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend && (!mem_req || mem_addr != paddr || mem_we != pwe)) proto_err++;
            pend  = mem_req && !mem_ack;
            paddr = mem_addr;
            pwe   = mem_we;
        end
    end

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input int a, input logic [7:0] d,
                          output logic [7:0] q, output int waits);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = d;
        waits = 0;
        #1;
        while (!cpu_ready && waits < 1000) begin
            @(negedge clk); #1; waits++;
        end
        q = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    // One access checked against a shadow model of the cache state.
    task automatic do_acc(input logic we, input int a, input logic [7:0] d);
        int idx, tag, waits, r0, w0, ew, er, eww;
        bit hit, dirty_evict;
        logic [7:0] q;
        string rq;
        idx = (a >> 3) % LINES;
        tag = a >> (3 + IW);
        hit = mv[idx] && (mtag[idx] == tag);
        dirty_evict = !hit && mv[idx] && md[idx];
        ew  = hit ? 0 : (dirty_evict ? 2*LAT + 3 : LAT + 2);
        er  = hit ? 0 : 1;
        eww = dirty_evict ? 1 : 0;
        if (hit) rq = we ? "R5" : "R3";
        else if (dirty_evict) rq = "R7";
        else if (mv[idx]) rq = "R8";
        else rq = we ? "R6" : "R4";
        r0 = nrd; w0 = nwr;
        access(we, a, d, q, waits);
        chk(rq, "ready wait cycles", waits, ew);
        chk(rq, "memory reads", nrd - r0, er);
        chk(rq, "memory writes", nwr - w0, eww);
        if (!we) chk("R1", $sformatf("read byte @%0h", a), q, rmem[a]);
        else rmem[a] = d;
        mv[idx] = 1'b1;
        mtag[idx] = tag;
        md[idx] = (hit ? md[idx] : 1'b0) | we;
    endtask

    task automatic maint(input bit inv);
        int w0, cyc, expw;
        string rq;
        rq = inv ? "R10" : "R9";
        expw = 0;
        for (int i = 0; i < LINES; i++) if (mv[i] && md[i]) expw++;
        w0 = nwr; wb_n = 0;
        @(negedge clk);
        if (inv) cmd_inval = 1'b1; else cmd_flush = 1'b1;
        @(posedge clk); #1;
        cmd_inval = 1'b0; cmd_flush = 1'b0;
        cyc = 0;
        @(negedge clk);
        while (!maint_done && cyc < 2000) begin @(negedge clk); cyc++; end
        chk("R11", "done pulse seen", maint_done, 1);
        @(negedge clk);
        chk("R11", "done pulse ends", maint_done, 0);
        chk(rq, "write-back count", nwr - w0, expw);
        for (int k = 1; k < wb_n; k++)
            chk(rq, "ascending index", wb_idx[k] > wb_idx[k-1], 1);
        for (int l = 0; l < NL; l++) begin
            bit same = 1'b1;
            for (int k = 0; k < 8; k++) if (bmem[l*8+k] !== rmem[l*8+k]) same = 1'b0;
            chk(rq, $sformatf("memory line %0d current", l), same, 1);
        end
        for (int i = 0; i < LINES; i++) begin
            md[i] = 1'b0;
            if (inv) mv[i] = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int tg [LINES];
        for (int i = 0; i < NB; i++) begin
            bmem[i] = init_byte(i);
            rmem[i] = init_byte(i);
        end
        for (int i = 0; i < LINES; i++) begin mv[i] = 0; md[i] = 0; mtag[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R2", "ready idle in reset", cpu_ready, 0);
        chk("R2", "no mem request in reset", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R2", "no mem request after reset", mem_req, 0);
        chk("R11", "done low after reset", maint_done, 0);

        // Sweep reads over two cache capacities: misses, hits, clean replaces.
        for (int a = 0; a < 64; a++) do_acc(1'b0, a, 8'h00);
        // Sparse writes over four capacities: write hits, allocates, dirty evictions.
        for (int a = 0; a < 128; a += 3) do_acc(1'b1, a, 8'(a) ^ 8'h5A);
        // Read everything back, including merged bytes of allocated lines.
        for (int a = 0; a < 128; a++) do_acc(1'b0, a, 8'h00);
        // Dirty a line in every index, then flush.
        for (int i = 0; i < LINES; i++) do_acc(1'b1, 256 + i*8 + i, 8'hC0 + 8'(i));
        maint(1'b0);
        for (int i = 0; i < LINES; i++) tg[i] = mtag[i];
        for (int i = 0; i < LINES; i++) do_acc(1'b0, ((tg[i] << IW) + i) * 8 + 1, 8'h00);
        maint(1'b0);
        // Partial dirtying, then invalidate-all; afterwards everything misses.
        for (int a = 512; a < 544; a += 5) do_acc(1'b1, a, 8'(a) ^ 8'h3C);
        do_acc(1'b0, 600, 8'h00);
        maint(1'b1);
        for (int i = 0; i < LINES; i++) do_acc(1'b0, 512 + i*8, 8'h00);
        for (int a = 512; a < 544; a++) do_acc(1'b0, a, 8'h00);
        chk("R12", "handshake violations", proto_err, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule